// File: doc/BRIEF.md
# Key-Guarded Watchdog Timer

This block counts tick pulses while enabled. When the count reaches a period picked by a 3-bit timeout select, it raises a sticky pending flag. Depending on a mode bit, it then either asks for a system reset with a fixed-length pulse or drives an interrupt line. Software sees one 32-bit control word. It can freely write the enable and mode bits at any time. Two actions need a 4-bit key of 0xA in a dedicated field of the same write: changing the timeout select, and restarting the count. This keeps a stray write from stretching the period or servicing the watchdog.

Software services the watchdog by writing a word that carries the clear key. Doing so zeroes the count and drops the pending flag. Status is always visible on a read port: the current configuration fields, plus the pending flag in the top bit.

Top module: `kwdt_top`

## Requirements
- R1: After a synchronous reset, `rd_data` is 0, `irq` is 0 and `rst_req` is 0. This means the watchdog is disabled, in interrupt mode, with select 0 and nothing pending.
- R2: The timeout select sits at `wr_data[22:20]` and reads back at `rd_data[22:20]`. A write loads it only when `wr_data[27:24]` equals 4'hA. Any other key value leaves it as it was.
- R3: Every write loads the enable bit from `wr_data[0]` and the mode bit from `wr_data[1]`, where 1 means reset mode and 0 means interrupt mode. Both read back at `rd_data[1:0]`, and the remaining read bits other than 31 and 22:20 read 0.
- R4: Once enabled from a zero count, the pending flag (`rd_data[31]`) becomes 1 on the 2^(10+sel)-th tick, and not before.
- R5: While the enable bit is 0, ticks do not advance the count and pending does not change.
- R6: A write with `wr_data[15:12]` equal to 4'hA zeroes the count and clears pending. A write with any other value in that field leaves both as they were.
- R7: In interrupt mode, `irq` equals the pending flag, and `rst_req` stays 0. After a timeout the count wraps to 0 and keeps counting.
- R8: In reset mode, `irq` is 0. `rst_req` goes high in the cycle after the expiring tick and stays high for exactly 4 cycles. Ticks during the pulse are ignored, and the count restarts from 0 once the pulse ends.
- R9: If a clear-key write falls in the same cycle as the expiring tick, the clear wins. Pending stays 0, no reset pulse starts, and the count restarts from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word being written |
| tick | input | 1 | Count-advance pulse, one clock wide per tick |
| rd_data | output | 32 | Status: pending[31], select[22:20], mode[1], enable[0] |
| irq | output | 1 | Timeout interrupt, interrupt mode only |
| rst_req | output | 1 | Reset request pulse, reset mode only |

## Verification
The assertions assume that reset is held for a few clocks at start-up, so that no status bit starts out unknown. They also assume that `wr_en` and `tick` are driven to known levels in every cycle. The bench drives all inputs on the falling edge and keeps reset high for several cycles before any write. Outside the single directed collision case, it parks `tick` low while it writes. As a result, each expiry comes from a counted run of ticks and not from a write racing the counter.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

    localparam int WORD_W   = 32;
    localparam int SEL_W    = 3;
    localparam logic [3:0] UNLOCK = 4'hA;

    // field positions inside the control word
    localparam int EN_BIT     = 0;
    localparam int MODE_BIT   = 1;
    localparam int CLRKEY_LO  = 12;
    localparam int SEL_LO     = 20;
    localparam int SELKEY_LO  = 24;
    localparam int PEND_BIT   = 31;

    typedef enum logic {
        MODE_IRQ   = 1'b0,
        MODE_RESET = 1'b1
    } wd_mode_e;

    typedef struct packed {
        logic             en;
        wd_mode_e         mode;
        logic [SEL_W-1:0] sel;
    } wd_cfg_t;

    typedef struct packed {
        logic             en;
        wd_mode_e         mode;
        logic [SEL_W-1:0] sel;
        logic             sel_ok;
        logic             clr_ok;
    } wd_cmd_t;

    function automatic wd_cmd_t decode_word(input logic [WORD_W-1:0] w);
        wd_cmd_t c;
        c.en     = w[EN_BIT];
        c.mode   = wd_mode_e'(w[MODE_BIT]);
        c.sel    = w[SEL_LO +: SEL_W];
        c.sel_ok = (w[SELKEY_LO +: 4] == UNLOCK);
        c.clr_ok = (w[CLRKEY_LO +: 4] == UNLOCK);
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] pack_status(input wd_cfg_t cfg, input logic pend);
        logic [WORD_W-1:0] s;
        s                    = '0;
        s[EN_BIT]            = cfg.en;
        s[MODE_BIT]          = cfg.mode;
        s[SEL_LO +: SEL_W]   = cfg.sel;
        s[PEND_BIT]          = pend;
        return s;
    endfunction

endpackage

// File: rtl/kwdt_regs.sv
module kwdt_regs
    import kwdt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    wr_en,
    input  wd_cmd_t cmd,
    input  logic    expire,
    output wd_cfg_t cfg,
    output logic    pend,
    output logic    clr_hit
);

    assign clr_hit = wr_en && cmd.clr_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.en   <= 1'b0;
            cfg.mode <= MODE_IRQ;
            cfg.sel  <= '0;
        end else if (wr_en) begin
            cfg.en   <= cmd.en;
            cfg.mode <= cmd.mode;
            if (cmd.sel_ok) begin
                cfg.sel <= cmd.sel;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
        end else if (clr_hit) begin
            pend <= 1'b0;
        end else if (expire) begin
            pend <= 1'b1;
        end
    end

endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter
    import kwdt_pkg::*;
#(
    parameter int BASE_LOG = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tick,
    input  logic [SEL_W-1:0] sel,
    input  logic             clr,
    input  logic             hold,
    output logic             expire
);

    localparam int CNT_W = BASE_LOG + (1 << SEL_W) - 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;
    logic             step;

    // last count value of the selected period: 2^(BASE_LOG+sel) - 1
    assign last   = (CNT_W'(1) << (BASE_LOG + int'(sel))) - CNT_W'(1);
    assign step   = en && tick && !clr && !hold;
    assign expire = step && (cnt >= last);

    always_ff @(posedge clk) begin
        if (rst || clr || hold) begin
            cnt <= '0;
        end else if (expire) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/kwdt_pulse.sv
module kwdt_pulse #(
    parameter int RST_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    output logic active
);

    localparam int LEN_W = $clog2(RST_LEN + 1);

    logic [LEN_W-1:0] left;

    assign active = (left != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            left <= '0;
        end else if (trig) begin
            left <= LEN_W'(RST_LEN);
        end else if (active) begin
            left <= left - LEN_W'(1);
        end
    end

endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
    import kwdt_pkg::*;
#(
    parameter int BASE_LOG = 10,
    parameter int RST_LEN  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              tick,
    output logic [WORD_W-1:0] rd_data,
    output logic              irq,
    output logic              rst_req
);

    wd_cmd_t cmd;
    wd_cfg_t cfg;
    logic    pend;
    logic    clr_hit;
    logic    expire;
    logic    pulse_on;

    assign cmd = decode_word(wr_data);

    kwdt_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .cmd     (cmd),
        .expire  (expire),
        .cfg     (cfg),
        .pend    (pend),
        .clr_hit (clr_hit)
    );

    kwdt_counter #(.BASE_LOG(BASE_LOG)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .en     (cfg.en),
        .tick   (tick),
        .sel    (cfg.sel),
        .clr    (clr_hit),
        .hold   (pulse_on),
        .expire (expire)
    );

    kwdt_pulse #(.RST_LEN(RST_LEN)) u_pulse (
        .clk    (clk),
        .rst    (rst),
        .trig   (expire && (cfg.mode == MODE_RESET)),
        .active (pulse_on)
    );

    assign rd_data = pack_status(cfg, pend);
    assign irq     = pend && (cfg.mode == MODE_IRQ);
    assign rst_req = pulse_on;

endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk #(
    parameter int RST_LEN = 4
) (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic        tick,
    input logic [31:0] rd_data,
    input logic        irq,
    input logic        rst_req
);

    localparam int HC_W = $clog2(RST_LEN + 1) + 1;

    logic [HC_W-1:0] high_cnt;

    always_ff @(posedge clk) begin
        if (rst || !rst_req) begin
            high_cnt <= '0;
        end else if (high_cnt != {HC_W{1'b1}}) begin
            high_cnt <= high_cnt + HC_W'(1);
        end
    end

    // R2
    sel_locked_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[27:24] != 4'hA) |=> $stable(rd_data[22:20]));

    // R2
    sel_unlocked_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[27:24] == 4'hA) |=> (rd_data[22:20] == $past(wr_data[22:20])));

    // R6
    clear_key_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[15:12] == 4'hA) |=> !rd_data[31]);

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !rd_data[0]) |=> $stable(rd_data[31]));

    // R7
    irq_source_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (rd_data[31] && !rd_data[1]));

    // R8
    pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_req) |-> (high_cnt == HC_W'(RST_LEN)));

    // R8
    pulse_cap_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> (high_cnt < HC_W'(RST_LEN)));

    // R8
    pulse_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_req) |-> rd_data[31]);

endmodule

bind kwdt_top kwdt_chk #(.RST_LEN(RST_LEN)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .tick    (tick),
    .rd_data (rd_data),
    .irq     (irq),
    .rst_req (rst_req)
);

// File: tb/sim_kwdt_top.sv
module sim_kwdt_top;

    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        tick = 1'b0;
    logic [31:0] rd_data;
    logic        irq;
    logic        rst_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // {word written, expected readback}, no ticks between entries
    localparam logic [63:0] VEC [NVEC] = '{
        {32'h0000_0001, 32'h0000_0001},  // R3 enable
        {32'h0A30_0001, 32'h0030_0001},  // R2 key ok, sel 3
        {32'h0B50_0001, 32'h0030_0001},  // R2 bad key, sel kept
        {32'h0050_0003, 32'h0030_0003},  // R2 no key; R3 mode
        {32'h0A00_0000, 32'h0000_0000},  // R2 sel 0, R3 disable
        {32'h0A70_0002, 32'h0070_0002},  // R2 sel 7
        {32'h0A00_A001, 32'h0000_0001},  // R6 clear with sel key
        {32'h00A0_0001, 32'h0000_0001}   // R2 key in wrong field
    };

    kwdt_top u0 (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .tick    (tick),
        .rd_data (rd_data),
        .irq     (irq),
        .rst_req (rst_req)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] w);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = w;
        @(posedge clk);
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    // n rising edges with tick high; ends on a falling edge, tick left high
    task automatic ticks(input int n);
        tick = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic tick_off();
        tick = 1'b0;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1
        chk("R1 rd_data", rd_data, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 rst_req", {31'b0, rst_req}, 32'h0);

        for (int v = 0; v < NVEC; v++) begin
            wr(VEC[v][63:32]);
            chk($sformatf("R2/R3 vec%0d", v), rd_data, VEC[v][31:0]);
        end

        // R4/R7: interrupt mode, sel 0
        wr(32'h0A00_A001);
        ticks(1023); tick_off();
        chk("R4 early", {31'b0, rd_data[31]}, 32'h0);
        chk("R7 irq low", {31'b0, irq}, 32'h0);
        ticks(1); tick_off();
        chk("R4 expire", {31'b0, rd_data[31]}, 32'h1);
        chk("R7 irq follows", {31'b0, irq}, 32'h1);
        chk("R7 no rst_req", {31'b0, rst_req}, 32'h0);

        // R6: wrong key keeps pending; good key clears count
        ticks(500); tick_off();
        wr(32'h0000_B001);
        chk("R6 bad key", {31'b0, rd_data[31]}, 32'h1);
        wr(32'h0000_A001);
        chk("R6 cleared", {31'b0, rd_data[31]}, 32'h0);
        chk("R6 irq dropped", {31'b0, irq}, 32'h0);
        ticks(1023); tick_off();
        chk("R6 count zeroed", {31'b0, rd_data[31]}, 32'h0);
        ticks(1); tick_off();
        chk("R6 refire", {31'b0, rd_data[31]}, 32'h1);

        // R5: disabled ignores ticks
        wr(32'h0000_A000);
        ticks(2000); tick_off();
        chk("R5 disabled", {31'b0, rd_data[31]}, 32'h0);
        wr(32'h0000_0001);
        ticks(1023); tick_off();
        chk("R5 count frozen", {31'b0, rd_data[31]}, 32'h0);

        // R4: sel 1 gives 2048 ticks
        wr(32'h0A10_A001);
        ticks(2047); tick_off();
        chk("R4 sel1 early", {31'b0, rd_data[31]}, 32'h0);
        ticks(1); tick_off();
        chk("R4 sel1 expire", {31'b0, rd_data[31]}, 32'h1);

        // R8: reset mode, sel 0
        wr(32'h0A00_A003);
        ticks(1023);
        chk("R8 before", {31'b0, rst_req}, 32'h0);
        ticks(1);
        chk("R8 pulse c1", {31'b0, rst_req}, 32'h1);
        chk("R8 irq low", {31'b0, irq}, 32'h0);
        chk("R8 pending", {31'b0, rd_data[31]}, 32'h1);
        for (int c = 2; c <= 4; c++) begin
            ticks(1);
            chk($sformatf("R8 pulse c%0d", c), {31'b0, rst_req}, 32'h1);
        end
        ticks(1);
        chk("R8 pulse end", {31'b0, rst_req}, 32'h0);
        ticks(1023);
        chk("R8 restart early", {31'b0, rst_req}, 32'h0);
        ticks(1); tick_off();
        chk("R8 restart fire", {31'b0, rst_req}, 32'h1);
        repeat (6) @(negedge clk);

        // R7: switching to interrupt mode exposes pending on irq
        wr(32'h0000_0001);
        chk("R7 mode switch", {31'b0, irq}, 32'h1);

        // R9: clear write coinciding with the expiring tick
        wr(32'h0000_A003);
        ticks(1023);
        wr_en   = 1'b1;
        wr_data = 32'h0000_A003;
        @(posedge clk);
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
        tick_off();
        chk("R9 no pending", {31'b0, rd_data[31]}, 32'h0);
        chk("R9 no pulse", {31'b0, rst_req}, 32'h0);
        ticks(1023); tick_off();
        chk("R9 restart early", {31'b0, rd_data[31]}, 32'h0);
        ticks(1); tick_off();
        chk("R9 restart fire", {31'b0, rd_data[31]}, 32'h1);

        done = 1'b1;
    end

    initial begin
        for (int k = 0; k < 100000; k++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule